// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Block

This block collects single-cycle event pulses from a peripheral's hardware into a sticky cause register. It drives one level-sensitive interrupt line towards the host whenever a recorded cause is also enabled in a mask register. Software reaches four word addresses through a plain address / write-enable / read-enable / data port.

The mask has two write addresses. One address only turns bits on and the other only turns bits off, so a driver never needs a read-modify-write sequence to change one enable. Pending causes are cleared by writing ones to the cause address. A separate set-only address lets software inject any cause for testing, and an injected cause passes through the same mask gating as a real event.

Address map (word offsets): 0 = cause (read, write-one-to-clear), 1 = mask set (read returns the mask), 2 = mask clear, 3 = cause inject. Only the low `NUM_CAUSES` bits of the data bus carry fields.

Top module: `irq_cause_mask`

## Requirements
- R1: After reset the mask and cause registers are zero, `irq_o` is low and `rdata_o` is zero.
- R2: A write to offset 1 ORs the low `NUM_CAUSES` written bits into the mask; zero bits leave mask bits unchanged.
- R3: A write to offset 2 clears every mask bit written as one; zero bits leave mask bits unchanged.
- R4: A one on `event_i[k]` sets cause bit k at the next clock edge whatever the mask holds.
- R5: A write to offset 0 clears every cause bit written as one; zero bits leave cause bits unchanged.
- R6: A write to offset 3 sets every cause bit written as one.
- R7: `irq_o` is high exactly when some bit is set in both cause and mask, so it follows the registers in the same cycle they change. It stays high until that condition is removed by a clear write.
- R8: When `event_i[k]` and a clear of cause bit k land in the same cycle, bit k ends set.
- R9: A read with `rd_en_i` high returns on `rdata_o` after the next clock edge: the cause at offset 0, the mask at offset 1, and zero at offsets 2, 3 and any other address. Bits at and above `NUM_CAUSES` read zero, and `rdata_o` holds its value while no read is made.
- R10: Reads change neither the cause nor the mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address of the access |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid the cycle after the read strobe |
| event_i | input | NUM_CAUSES | Hardware event pulses, one per cause |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The hardest case to reach from the ports is a hardware event that lands in the same cycle as a software clear of the same bit. A related case is a cause that arrives while masked and only raises the interrupt once it is unmasked later. Directed steps build both situations explicitly. The random phase keeps events sparse but overlaps them with random writes to every offset, including the cause-clear offset. This mixes collisions with mask changes and reads of every address.

// File: rtl/irq_cm_pkg.sv
package irq_cm_pkg;
   localparam int unsigned OFS_CAUSE     = 0;
   localparam int unsigned OFS_MASK_SET  = 1;
   localparam int unsigned OFS_MASK_CLR  = 2;
   localparam int unsigned OFS_CAUSE_SET = 3;

   typedef struct packed {
      logic mask_set;
      logic mask_clr;
      logic cause_clr;
      logic cause_set;
   } wr_dec_t;

   typedef enum logic [1:0] {
      RSEL_ZERO  = 2'd0,
      RSEL_CAUSE = 2'd1,
      RSEL_MASK  = 2'd2
   } rd_sel_e;
endpackage

// File: rtl/irq_cm_decode.sv
module irq_cm_decode
   import irq_cm_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   output wr_dec_t           wr_o,
   output rd_sel_e           sel_o
);
   localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
   localparam logic [ADDR_W-1:0] A_MSET  = ADDR_W'(OFS_MASK_SET);
   localparam logic [ADDR_W-1:0] A_MCLR  = ADDR_W'(OFS_MASK_CLR);
   localparam logic [ADDR_W-1:0] A_CSET  = ADDR_W'(OFS_CAUSE_SET);

   always_comb begin
      wr_o.mask_set  = wr_en_i && (addr_i == A_MSET);
      wr_o.mask_clr  = wr_en_i && (addr_i == A_MCLR);
      wr_o.cause_clr = wr_en_i && (addr_i == A_CAUSE);
      wr_o.cause_set = wr_en_i && (addr_i == A_CSET);
      if (addr_i == A_CAUSE)     sel_o = RSEL_CAUSE;
      else if (addr_i == A_MSET) sel_o = RSEL_MASK;
      else                       sel_o = RSEL_ZERO;
   end
endmodule

// File: rtl/irq_cm_mask.sv
module irq_cm_mask #(
   parameter int unsigned N = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         set_en_i,
   input  logic         clr_en_i,
   input  logic [N-1:0] bits_i,
   output logic [N-1:0] mask_o
);
   logic [N-1:0] set_v, clr_v;

   assign set_v = set_en_i ? bits_i : '0;
   assign clr_v = clr_en_i ? bits_i : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_o <= '0;
      else         mask_o <= (mask_o | set_v) & ~clr_v;
   end
endmodule

// File: rtl/irq_cm_cause.sv
module irq_cm_cause #(
   parameter int unsigned N = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] event_i,
   input  logic         set_en_i,
   input  logic         clr_en_i,
   input  logic [N-1:0] bits_i,
   output logic [N-1:0] cause_o
);
   for (genvar k = 0; k < N; k++) begin : g_bit
      logic raise, drop;
      assign raise = event_i[k] | (set_en_i & bits_i[k]);
      assign drop  = clr_en_i & bits_i[k];
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)    cause_o[k] <= 1'b0;
         else if (raise) cause_o[k] <= 1'b1;
         else if (drop)  cause_o[k] <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_cm_rdmux.sv
module irq_cm_rdmux
   import irq_cm_pkg::*;
#(
   parameter int unsigned N         = 16,
   parameter int unsigned DATA_W    = 32,
   parameter bit          REG_RDATA = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rd_en_i,
   input  rd_sel_e           sel_i,
   input  logic [N-1:0]      cause_i,
   input  logic [N-1:0]      mask_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] mux_d;

   always_comb begin
      unique case (sel_i)
         RSEL_CAUSE: mux_d = DATA_W'(cause_i);
         RSEL_MASK:  mux_d = DATA_W'(mask_i);
         default:    mux_d = '0;
      endcase
   end

   if (REG_RDATA) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      rdata_o <= '0;
         else if (rd_en_i) rdata_o <= mux_d;
      end
   end else begin : g_comb
      assign rdata_o = rd_en_i ? mux_d : '0;
   end
endmodule

// File: rtl/irq_cause_mask.sv
module irq_cause_mask
   import irq_cm_pkg::*;
#(
   parameter int unsigned NUM_CAUSES = 16,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 4,
   parameter bit          REG_RDATA  = 1'b1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic                  wr_en_i,
   input  logic                  rd_en_i,
   input  logic [DATA_W-1:0]     wdata_i,
   output logic [DATA_W-1:0]     rdata_o,
   input  logic [NUM_CAUSES-1:0] event_i,
   output logic                  irq_o
);
   if (NUM_CAUSES < 1 || NUM_CAUSES > DATA_W) begin : g_bad_width
      $error("NUM_CAUSES must be between 1 and DATA_W");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must cover four offsets");
   end

   wr_dec_t                 wr_dec;
   rd_sel_e                 rd_sel;
   logic [NUM_CAUSES-1:0]   wbits;
   logic [NUM_CAUSES-1:0]   mask_q;
   logic [NUM_CAUSES-1:0]   cause_q;

   assign wbits = wdata_i[NUM_CAUSES-1:0];

   irq_cm_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr_i  (addr_i),
      .wr_en_i (wr_en_i),
      .wr_o    (wr_dec),
      .sel_o   (rd_sel)
   );

   irq_cm_mask #(.N(NUM_CAUSES)) u_mask (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_en_i (wr_dec.mask_set),
      .clr_en_i (wr_dec.mask_clr),
      .bits_i   (wbits),
      .mask_o   (mask_q)
   );

   irq_cm_cause #(.N(NUM_CAUSES)) u_cause (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .event_i  (event_i),
      .set_en_i (wr_dec.cause_set),
      .clr_en_i (wr_dec.cause_clr),
      .bits_i   (wbits),
      .cause_o  (cause_q)
   );

   irq_cm_rdmux #(.N(NUM_CAUSES), .DATA_W(DATA_W), .REG_RDATA(REG_RDATA)) u_rdmux (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rd_en_i (rd_en_i),
      .sel_i   (rd_sel),
      .cause_i (cause_q),
      .mask_i  (mask_q),
      .rdata_o (rdata_o)
   );

   assign irq_o = |(cause_q & mask_q);
endmodule

// File: rtl/irq_cause_mask_chk.sv
module irq_cause_mask_chk #(
   parameter int unsigned NUM_CAUSES = 16,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 4
) (
   input logic                  clk_i,
   input logic                  rst_ni,
   input logic [ADDR_W-1:0]     addr_i,
   input logic                  wr_en_i,
   input logic                  rd_en_i,
   input logic [DATA_W-1:0]     wdata_i,
   input logic [DATA_W-1:0]     rdata_o,
   input logic [NUM_CAUSES-1:0] event_i,
   input logic                  irq_o,
   input logic [NUM_CAUSES-1:0] mask_q,
   input logic [NUM_CAUSES-1:0] cause_q
);
   logic [NUM_CAUSES-1:0] wb;
   logic wr_cause, wr_mset, wr_mclr;
   assign wb       = wdata_i[NUM_CAUSES-1:0];
   assign wr_cause = wr_en_i && (addr_i == ADDR_W'(0));
   assign wr_mset  = wr_en_i && (addr_i == ADDR_W'(1));
   assign wr_mclr  = wr_en_i && (addr_i == ADDR_W'(2));

   assert_mask_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_mset |=> ((mask_q & $past(wb)) == $past(wb)));

   assert_mask_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_mclr |=> ((mask_q & $past(wb)) == '0));

   // R4 and R8: an event bit always lands, even against a clear
   assert_event_sticks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|event_i) |=> ((cause_q & $past(event_i)) == $past(event_i)));

   assert_cause_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_cause |=> ((cause_q & $past(wb) & ~$past(event_i)) == '0));

   assert_irq_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && !wr_cause && !wr_mclr) |=> irq_o);

   assert_enabled_event_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (((event_i & mask_q) != '0) && !wr_mclr) |=> irq_o);

   assert_zero_offsets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && (addr_i == ADDR_W'(2) || addr_i == ADDR_W'(3))) |=> (rdata_o == '0));

   assert_read_no_side_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && !wr_en_i && event_i == '0) |=> ($stable(cause_q) && $stable(mask_q)));
endmodule

bind irq_cause_mask irq_cause_mask_chk #(
   .NUM_CAUSES(NUM_CAUSES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .addr_i  (addr_i),
   .wr_en_i (wr_en_i),
   .rd_en_i (rd_en_i),
   .wdata_i (wdata_i),
   .rdata_o (rdata_o),
   .event_i (event_i),
   .irq_o   (irq_o),
   .mask_q  (mask_q),
   .cause_q (cause_q)
);

// File: tb/irq_cause_mask_tb.sv
`timescale 1ns/1ps
module irq_cause_mask_tb;
   localparam int NC = 16;
   localparam int DW = 32;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_ni = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic [NC-1:0] evt = '0;
   logic          irq;

   int n_checks = 0, n_fail = 0;
   logic [NC-1:0] m_mask = '0, m_cause = '0;
   logic [DW-1:0] m_rd = '0;

   always #4 clk = ~clk;

   irq_cause_mask #(.NUM_CAUSES(NC), .DATA_W(DW), .ADDR_W(AW)) u_dut (
      .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .wdata_i(wdata), .rdata_o(rdata), .event_i(evt), .irq_o(irq)
   );

   function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
      if (a == 0) return DW'(m_cause);
      if (a == 1) return DW'(m_mask);
      return '0;
   endfunction

   function automatic logic [NC-1:0] nxt_mask(input logic [AW-1:0] a, input logic w,
                                              input logic [NC-1:0] d);
      logic [NC-1:0] r = m_mask;
      if (w && a == 1) r = r | d;
      if (w && a == 2) r = r & ~d;
      return r;
   endfunction

   function automatic logic [NC-1:0] nxt_cause(input logic [AW-1:0] a, input logic w,
                                               input logic [NC-1:0] d, input logic [NC-1:0] e);
      logic [NC-1:0] r = m_cause;
      if (w && a == 0) r = r & ~d;
      if (w && a == 3) r = r | d;
      return r | e;
   endfunction

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [AW-1:0] a, input logic w, input logic r,
                       input logic [DW-1:0] d, input logic [NC-1:0] e,
                       input string tag_rd, input string tag_irq);
      @(negedge clk);
      addr = a; wr_en = w; rd_en = r; wdata = d; evt = e;
      if (r) m_rd = exp_read(a);
      m_mask  = nxt_mask(a, w, d[NC-1:0]);
      m_cause = nxt_cause(a, w, d[NC-1:0], e);
      @(posedge clk);
      #2;
      check(tag_rd, rdata, m_rd);
      check(tag_irq, DW'(irq), DW'(|(m_cause & m_mask)));
      addr = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0; evt = '0;
   endtask

   task automatic idle_read(input logic [AW-1:0] a, input string tag);
      step(a, 1'b0, 1'b1, '0, '0, tag, tag);
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd20240611);
      repeat (3) @(posedge clk);
      #2;
      check("R1 irq at reset", DW'(irq), '0);
      check("R1 rdata at reset", rdata, '0);
      @(negedge clk) rst_ni = 1'b1;
      idle_read(0, "R1 cause after reset");
      idle_read(1, "R1 mask after reset");

      // masked event is still recorded
      step(0, 1'b0, 1'b0, '0, 16'h0010, "R4 masked event", "R4 masked no irq");
      check("R4 irq stays low while masked", DW'(irq), '0);
      idle_read(0, "R4 cause shows masked event");
      // unmask: irq follows in the cycle after the write
      step(1, 1'b1, 1'b0, 32'hFFFF_0010, '0, "R2 mask set", "R7 unmask raises irq");
      check("R7 irq high after unmask", DW'(irq), 32'd1);
      idle_read(1, "R2 upper bits ignored");
      step(1, 1'b1, 1'b0, 32'h0000_0300, '0, "R2 OR into mask", "R7 irq");
      idle_read(1, "R2 zero bits keep mask");
      // collision: event and clear on the same bit
      step(0, 1'b1, 1'b0, 32'h0000_0010, 16'h0010, "R8 collision", "R8 irq holds");
      idle_read(0, "R8 bit survives clear");
      step(0, 1'b1, 1'b0, 32'h0000_0010, '0, "R5 clear", "R7 irq drops");
      check("R7 irq low after clear", DW'(irq), '0);
      // software injection through the mask
      step(3, 1'b1, 1'b0, 32'h0000_8200, '0, "R6 inject", "R6 inject gated");
      idle_read(0, "R6 cause after inject");
      step(2, 1'b1, 1'b0, 32'h0000_0200, '0, "R3 mask clear", "R3 irq gated off");
      idle_read(1, "R3 mask after clear");
      idle_read(2, "R9 mask-clear offset reads zero");
      idle_read(3, "R9 inject offset reads zero");
      idle_read(4'hA, "R9 unused offset reads zero");
      step(0, 1'b1, 1'b0, 32'h0000_0200, '0, "R5 partial clear", "R5 irq");
      idle_read(0, "R5 zero bits keep cause");
      step(0, 1'b0, 1'b0, '0, '0, "R9 rdata holds", "R10 idle");
      idle_read(0, "R10 repeat read unchanged");

      for (int i = 0; i < 600; i++) begin
         logic [AW-1:0] a;
         logic [NC-1:0] e;
         a = AW'($urandom % 6);
         e = ($urandom % 4 == 0) ? NC'($urandom & $urandom) : '0;
         step(a, 1'($urandom), 1'($urandom), $urandom, e, "R9 random read", "R7 random irq");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule